// File: doc/BRIEF.md
# Vectored IRQ Priority and Address Unit

This unit looks at 32 raw interrupt request lines together with an enable mask and a route mask. The route mask sends each line either to IRQ or to the fast path. It then decides which IRQ handler should run next. Sixteen programmable slots each bind one source to a 32-bit handler address. Slot 0 has the highest priority and slot 15 the lowest. A default handler address, ranked below every slot, covers any active IRQ source that no enabled slot claims.

Software reaches the unit through a small word-addressed register bus. A request is a single-cycle `req_valid` pulse. The unit never stalls, so there is no ready signal. Every request, read or write, gets exactly one `rsp_valid` pulse on the following cycle, and `rsp_rdata` carries the read data.

The servicing protocol is driven by register access. Reading the current-vector register returns the handler address and pushes that priority level onto an in-service stack. Writing the register, with any data, pops the most recent level. While a level is in service, only strictly higher-priority requests raise `irq_out`.

Register map (6-bit word address): `0x00`–`0x0F` are the slot handler addresses and `0x10`–`0x1F` are the slot control words. `0x20` is the default handler address and `0x21` is the current-vector register. Addresses `0x22`–`0x3F` read as zero and ignore writes.

Top module: `irq_vector_arbiter`

## Requirements
- R1: After reset, all slot control words, slot addresses and the default address read as zero, and no level is in service.
- R2: Slot handler address and default address registers store all 32 bits. A slot control word stores bit 5 (slot enable) and bits 4:0 (source number), and reads bits 31:6 as zero. Every register access is answered by `rsp_valid` exactly one cycle after `req_valid`.
- R3: A slot requests only when three conditions all hold: its source bit is set in `irq_raw`, that source is set in `irq_en`, and that source is clear in `fiq_route` (0 = IRQ, 1 = fast path). The slot's enable bit must also be set.
- R4: Among requesting slots, the lowest-numbered one has priority, and a current-vector read returns its handler address.
- R5: The default handler address is returned for an active IRQ source that no enabled slot selects. The default level ranks below slot 15.
- R6: `irq_out` is high exactly when the best requesting level ranks strictly above the top in-service level. With nothing in service, any active IRQ source counts.
- R7: A current-vector read while `irq_out` is high pushes the winning level. After that, requests at that level or lower no longer raise `irq_out`.
- R8: A current-vector write while something is in service pops only the most recently pushed level.
- R9: A current-vector write with nothing in service leaves the stack unchanged.
- R10: A current-vector read while `irq_out` is low returns the default address and leaves the stack unchanged.
- R11: Sources routed to the fast path, or masked in `irq_en`, raise neither slot requests nor the default request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_raw | input | 32 | Raw interrupt request lines |
| irq_en | input | 32 | Per-source enable mask |
| fiq_route | input | 32 | Per-source route, 1 = fast path, 0 = IRQ |
| req_valid | input | 1 | Register access request, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach from the ports is a deep nest of in-service levels. In that state a lower-priority request is pending and must stay hidden, and a pop must then expose the correct level beneath it. The bench reaches this state with long runs of sparse random source patterns interleaved with vector reads and writes. Each response is compared against a bench-side stack model, so nests several levels deep build up and unwind in varying orders. Directed sequences add a blocked lower-priority request, a write with nothing in service, and an exhaustive sweep of the three gating conditions on every slot.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  localparam int ADDR_W   = 6;
  localparam int EN_BIT   = 5;
  localparam int SRC_BITS = 5;
  localparam logic [1:0] RGN_ADDR = 2'b00;
  localparam logic [1:0] RGN_CTRL = 2'b01;
  localparam logic [1:0] RGN_MISC = 2'b10;
  localparam logic [ADDR_W-1:0] A_DEFAULT = 6'h20;
  localparam logic [ADDR_W-1:0] A_VECTOR  = 6'h21;
endpackage

// File: rtl/ivu_slot_bank.sv
module ivu_slot_bank #(
  parameter int NUM_SLOT = 16,
  parameter int DW       = 32,
  parameter int SRC_W    = 5,
  localparam int SLOT_W  = $clog2(NUM_SLOT)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_addr,
  input  logic                          wr_ctrl,
  input  logic [SLOT_W-1:0]             wr_idx,
  input  logic [DW-1:0]                 wr_data,
  output logic [NUM_SLOT-1:0][DW-1:0]   slot_addr,
  output logic [NUM_SLOT-1:0]           slot_en,
  output logic [NUM_SLOT-1:0][SRC_W-1:0] slot_src
);
  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_addr[i] <= '0;
        slot_en[i]   <= 1'b0;
        slot_src[i]  <= '0;
      end else begin
        if (wr_addr && wr_idx == SLOT_W'(i)) slot_addr[i] <= wr_data;
        if (wr_ctrl && wr_idx == SLOT_W'(i)) begin
          slot_en[i]  <= wr_data[ivu_pkg::EN_BIT];
          slot_src[i] <= wr_data[SRC_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/ivu_pick.sv
module ivu_pick #(
  parameter int NUM_SLOT = 16,
  parameter int NUM_SRC  = 32,
  parameter int SRC_W    = 5,
  localparam int LVL_W   = $clog2(NUM_SLOT + 2)
) (
  input  logic [NUM_SRC-1:0]             active,
  input  logic [NUM_SLOT-1:0]            slot_en,
  input  logic [NUM_SLOT-1:0][SRC_W-1:0] slot_src,
  output logic [LVL_W-1:0]               best_lvl
);
  logic [NUM_SLOT:0]    req;
  logic [NUM_SRC-1:0]   claimed;

  always_comb begin
    claimed = '0;
    for (int i = 0; i < NUM_SLOT; i++) begin
      req[i] = slot_en[i] && active[slot_src[i]];
      if (slot_en[i]) claimed[slot_src[i]] = 1'b1;
    end
    req[NUM_SLOT] = |(active & ~claimed);
  end

  always_comb begin
    best_lvl = LVL_W'(NUM_SLOT + 1);
    for (int i = NUM_SLOT; i >= 0; i--)
      if (req[i]) best_lvl = LVL_W'(i);
  end
endmodule

// File: rtl/ivu_service_stack.sv
module ivu_service_stack #(
  parameter int NUM_LVL = 17,
  localparam int LVL_W  = $clog2(NUM_LVL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [LVL_W-1:0]   push_lvl,
  input  logic               pop,
  output logic [NUM_LVL-1:0] in_service,
  output logic [LVL_W-1:0]   cur_lvl
);
  always_comb begin
    cur_lvl = LVL_W'(NUM_LVL);
    for (int i = NUM_LVL - 1; i >= 0; i--)
      if (in_service[i]) cur_lvl = LVL_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_service <= '0;
    else if (push) in_service[push_lvl] <= 1'b1;
    else if (pop && in_service != '0) in_service[cur_lvl] <= 1'b0;
  end
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter #(
  parameter int NUM_SLOT = 16,
  parameter int NUM_SRC  = 32,
  parameter int DW       = 32,
  localparam int SRC_W   = $clog2(NUM_SRC),
  localparam int SLOT_W  = $clog2(NUM_SLOT),
  localparam int NUM_LVL = NUM_SLOT + 1,
  localparam int LVL_W   = $clog2(NUM_LVL + 1),
  localparam int AW      = ivu_pkg::ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_raw,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic [NUM_SRC-1:0] fiq_route,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [DW-1:0]      req_wdata,
  output logic               rsp_valid,
  output logic [DW-1:0]      rsp_rdata,
  output logic               irq_out
);
  import ivu_pkg::*;

  logic [NUM_SLOT-1:0][DW-1:0]    slot_addr;
  logic [NUM_SLOT-1:0]            slot_en;
  logic [NUM_SLOT-1:0][SRC_W-1:0] slot_src;
  logic [DW-1:0]                  def_addr;
  logic [NUM_SRC-1:0]             active;
  logic [LVL_W-1:0]               best_lvl, cur_lvl;
  logic [NUM_LVL-1:0]             in_service;
  logic [1:0]                     rgn;
  logic [SLOT_W-1:0]              idx;
  logic                           wr_a, wr_c, vec_rd, vec_wr;
  logic [DW-1:0]                  rd_mux, win_addr;

  assign active = irq_raw & irq_en & ~fiq_route;
  assign rgn    = req_addr[AW-1:AW-2];
  assign idx    = req_addr[SLOT_W-1:0];
  assign wr_a   = req_valid && req_write && rgn == RGN_ADDR;
  assign wr_c   = req_valid && req_write && rgn == RGN_CTRL;
  assign vec_rd = req_valid && !req_write && req_addr == A_VECTOR;
  assign vec_wr = req_valid && req_write && req_addr == A_VECTOR;

  ivu_slot_bank #(.NUM_SLOT(NUM_SLOT), .DW(DW), .SRC_W(SRC_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_a), .wr_ctrl(wr_c), .wr_idx(idx),
    .wr_data(req_wdata), .slot_addr(slot_addr), .slot_en(slot_en), .slot_src(slot_src)
  );

  ivu_pick #(.NUM_SLOT(NUM_SLOT), .NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_pick (
    .active(active), .slot_en(slot_en), .slot_src(slot_src), .best_lvl(best_lvl)
  );

  assign irq_out = best_lvl < cur_lvl;

  ivu_service_stack #(.NUM_LVL(NUM_LVL)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(vec_rd && irq_out), .push_lvl(best_lvl),
    .pop(vec_wr), .in_service(in_service), .cur_lvl(cur_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) def_addr <= '0;
    else if (req_valid && req_write && req_addr == A_DEFAULT) def_addr <= req_wdata;
  end

  always_comb begin
    if (irq_out && best_lvl < LVL_W'(NUM_SLOT)) win_addr = slot_addr[best_lvl[SLOT_W-1:0]];
    else win_addr = def_addr;
  end

  always_comb begin
    rd_mux = '0;
    case (rgn)
      RGN_ADDR: rd_mux = slot_addr[idx];
      RGN_CTRL: begin
        rd_mux[EN_BIT]     = slot_en[idx];
        rd_mux[SRC_W-1:0]  = slot_src[idx];
      end
      RGN_MISC: begin
        if (req_addr == A_DEFAULT) rd_mux = def_addr;
        else if (req_addr == A_VECTOR) rd_mux = win_addr;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/irq_vector_checker.sv
module irq_vector_checker #(
  parameter int NUM_LVL = 17,
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_raw,
  input logic [NUM_SRC-1:0] irq_en,
  input logic [NUM_SRC-1:0] fiq_route,
  input logic               req_valid,
  input logic               req_write,
  input logic [5:0]         req_addr,
  input logic               rsp_valid,
  input logic               irq_out,
  input logic [NUM_LVL-1:0] in_service
);
  logic vrd, vwr;
  assign vrd = req_valid && !req_write && req_addr == 6'h21;
  assign vwr = req_valid && req_write && req_addr == 6'h21;

  a_r2_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r6_idle_any_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service == '0 && |(irq_raw & irq_en & ~fiq_route)) |-> irq_out);
  a_r11_no_active: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_raw & irq_en & ~fiq_route) == '0 |-> !irq_out);
  a_r7_push_one: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd && irq_out) |=> $countones(in_service) == $countones($past(in_service)) + 1);
  a_r8_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (vwr && in_service != '0) |=> $countones(in_service) + 1 == $countones($past(in_service)));
  a_r9_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
    (vwr && in_service == '0) |=> in_service == '0);
  a_r10_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd && !irq_out) |=> $stable(in_service));
endmodule

bind irq_vector_arbiter irq_vector_checker #(.NUM_LVL(NUM_LVL), .NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .irq_en(irq_en), .fiq_route(fiq_route),
  .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .irq_out(irq_out), .in_service(in_service)
);

// File: tb/tb_irq_vector_arbiter.sv
module tb_irq_vector_arbiter;
  logic clk = 0, rst_n = 0;
  logic [31:0] irq_raw = 0, irq_en = 0, fiq_route = 0, req_wdata = 0;
  logic req_valid = 0, req_write = 0;
  logic [5:0] req_addr = 0;
  logic rsp_valid, irq_out;
  logic [31:0] rsp_rdata;
  int total = 0, bad = 0;

  irq_vector_arbiter dut (.*);
  always #2 clk = ~clk;

  logic [31:0] m_addr [16];
  logic        m_en   [16];
  logic [4:0]  m_src  [16];
  logic [31:0] m_def;
  logic [16:0] m_ins;

  function automatic int best();
    logic [31:0] act, clm;
    act = irq_raw & irq_en & ~fiq_route;
    clm = 0;
    for (int i = 0; i < 16; i++) if (m_en[i]) clm[m_src[i]] = 1;
    for (int i = 0; i < 16; i++) if (m_en[i] && act[m_src[i]]) return i;
    if ((act & ~clm) != 0) return 16;
    return 17;
  endfunction

  function automatic int cur();
    for (int i = 0; i < 17; i++) if (m_ins[i]) return i;
    return 17;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus(bit wr, logic [5:0] a, logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    q = rsp_rdata;
    if (rsp_valid !== 1'b1) begin total++; bad++; $display("FAIL R2 rsp_valid got=0 exp=1"); end
  endtask

  task automatic check_irq(string tag);
    #1 chk(tag, {31'b0, irq_out}, {31'b0, best() < cur()});
  endtask

  task automatic vread(string tag);
    logic [31:0] q, e;
    int b, c;
    b = best(); c = cur();
    e = (b < c && b < 16) ? m_addr[b] : m_def;
    if (b < c) m_ins[b] = 1;
    bus(0, 6'h21, 0, q);
    chk(tag, q, e);
  endtask

  task automatic vwrite();
    logic [31:0] q;
    int c;
    c = cur();
    if (c < 17) m_ins[c] = 0;
    bus(1, 6'h21, $urandom, q);
  endtask

  task automatic set_ctrl(int i, bit en, logic [4:0] s);
    logic [31:0] q;
    m_en[i] = en; m_src[i] = s;
    bus(1, 6'h10 + 6'(i), 32'hFFFF_FFC0 & $urandom | {26'b0, en, s}, q);
  endtask

  function automatic logic [31:0] sbit(int i);
    return 32'h1 << m_src[i];
  endfunction

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] q;
    for (int i = 0; i < 16; i++) begin m_addr[i] = 0; m_en[i] = 0; m_src[i] = 0; end
    m_def = 0; m_ins = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 16; i++) begin
      bus(0, 6'h10 + 6'(i), 0, q); chk("R1 ctrl", q, 0);
      bus(0, 6'(i), 0, q); chk("R1 addr", q, 0);
    end
    bus(0, 6'h20, 0, q); chk("R1 default", q, 0);
    check_irq("R1 irq idle");
    vread("R10 idle read");
    // R2 programming
    m_def = 32'hDEF0_0000;
    bus(1, 6'h20, m_def, q);
    for (int i = 0; i < 16; i++) begin
      m_addr[i] = 32'hA000_0000 + 32'(i) * 32'h111;
      bus(1, 6'(i), m_addr[i], q);
      set_ctrl(i, i != 9, 5'((i * 5 + 2) % 32));
    end
    for (int i = 0; i < 16; i++) begin
      bus(0, 6'(i), 0, q); chk("R2 addr readback", q, m_addr[i]);
      bus(0, 6'h10 + 6'(i), 0, q); chk("R2 ctrl readback", q, {26'b0, m_en[i], m_src[i]});
    end
    bus(0, 6'h20, 0, q); chk("R2 default", q, m_def);
    bus(0, 6'h30, 0, q); chk("R2 unmapped", q, 0);
    // R3 / R11: sweep gating conditions on every slot
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 8; k++) begin
        if (k[2] != m_en[i]) set_ctrl(i, k[2], m_src[i]);
        @(negedge clk);
        irq_raw = sbit(i); irq_en = k[0] ? sbit(i) : 0; fiq_route = k[1] ? sbit(i) : 0;
        check_irq("R3 gating irq");
        vread("R3 gating vector");
        if (m_ins != 0) vwrite();
        chk("R3 stack empty", {15'b0, m_ins}, 0);
      end
      set_ctrl(i, i != 9, m_src[i]);
    end
    // R4 priority: two slots at once, lower index wins
    @(negedge clk);
    irq_en = '1; fiq_route = 0;
    irq_raw = sbit(3) | sbit(12);
    check_irq("R4 irq"); vread("R4 slot3 wins");
    // R7 lower request blocked, higher preempts
    @(negedge clk); irq_raw = sbit(3) | sbit(12) | sbit(7);
    check_irq("R7 lower blocked");
    chk("R7 irq low", {31'b0, irq_out}, 0);
    @(negedge clk); irq_raw = irq_raw | sbit(1);
    check_irq("R7 higher preempts");
    vread("R7 nested slot1");
    vread("R10 read no higher");
    vwrite(); check_irq("R8 pop to slot3");
    chk("R8 stack top", {15'b0, m_ins}, 17'h8);
    vwrite(); check_irq("R8 pop all");
    vwrite(); check_irq("R9 idle write");
    chk("R9 stack", {15'b0, m_ins}, 0);
    // R5 default: source 31 not claimed by any slot (slot 9 disabled owns 15)
    @(negedge clk); irq_raw = 32'h8000_0000;
    check_irq("R5 default irq");
    vread("R5 default vector");
    @(negedge clk); irq_raw = 32'h8000_0000 | sbit(15);
    check_irq("R5 slot15 above default");
    vread("R5 slot15 vector");
    vwrite(); vwrite();
    // R11 fast-path routed source ignored
    @(negedge clk); irq_raw = 32'h8000_0000; fiq_route = 32'h8000_0000;
    check_irq("R11 fiq route"); chk("R11 irq low", {31'b0, irq_out}, 0);
    fiq_route = 0;
    // R6/R7/R8 random nesting against model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      irq_raw = $urandom & $urandom & $urandom;
      irq_en = $urandom | $urandom;
      fiq_route = $urandom & $urandom & $urandom;
      check_irq("R6 random irq");
      if ($urandom % 3 != 0) vread("R7 random vector"); else vwrite();
    end
    while (m_ins != 0) vwrite();
    check_irq("R8 unwind");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule